// File: doc/BRIEF.md
# Core Voltage Power-Good Monitor

This block judges the health of a processor core supply from digital samples. A 5-bit voltage-identification code selects the programmed core reference in millivolts. A non-inhibit code maps onto one of two ranges: a coarse range with 100 mV steps and a fine range with 50 mV steps. Several codes are reserved. They shut the supply off and raise an inhibit flag instead of giving a reference.

Each strobed core reading in millivolts is compared against percentage thresholds of the reference. The upper and lower window edges each carry their own hysteresis state. From these comparisons the block produces a registered power-good flag and an over-voltage trip. Two undervoltage-OK flags from the linear outputs also gate power-good. Analog sensing, conversion and pin drivers sit outside the block.

Top module: `core_pgood_mon`

## Requirements
- R1: For a code with bit 4 = 1 and bits 3..0 other than 1111, the reference is 3500 - 100*bits[3:0] mV (1110 gives 2100, 0000 gives 3500). It appears on `ref_mv_o` one clock after the code is applied, and `inhibit_o` is 0.
- R2: For codes 00000 to 00101, the reference is 2050 - 50*bits[2:0] mV (00101 gives 1800). `inhibit_o` is 0.
- R3: Codes 01xxx, 0011x and 11111 set `inhibit_o` and give a reference of 0. While `inhibit_o` is high, `pgood_o` is driven high on the next clock, and a strobed sample clears `ov_trip_o`.
- R4: The upper edge trips when a strobed reading is at least floor(ref*110/100). It releases only when a reading falls below floor(ref*108/100). While it is tripped, `pgood_o` is low.
- R5: The lower edge becomes satisfied when a strobed reading is at least floor(ref*93/100). It is lost only when a reading falls below floor(ref*91/100). While it is not satisfied, `pgood_o` is low.
- R6: If the code is not an inhibit code and either linear OK flag is 0, `pgood_o` is 0 on the next clock. Otherwise `pgood_o` follows the window one clock after the edge state.
- R7: On a strobe with a non-inhibit reference, `ov_trip_o` becomes 1 if the reading exceeds floor(ref*115/100), and 0 otherwise.
- R8: When `sample_valid_i` is low, the core reading has no effect. Both edge states and `ov_trip_o` hold their values.
- R9: During and after reset, `ref_mv_o`, `inhibit_o`, `ov_trip_o` and `pgood_o` are 0. Power-good stays low until a strobed in-window sample has been taken.
- R10: A code change reloads the reference on the next clock with no other action. An inhibit code clears both edge states, so after leaving inhibit, power-good waits for a fresh in-window sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vid_code_i | input | 5 | Voltage-identification code |
| sample_valid_i | input | 1 | Strobe marking a valid core reading |
| core_mv_i | input | MV_W | Core output reading in mV |
| lin_a_ok_i | input | 1 | First linear output above its undervoltage level |
| lin_b_ok_i | input | 1 | Second linear output above its undervoltage level |
| ref_mv_o | output | MV_W | Decoded reference in mV, 0 when inhibited |
| inhibit_o | output | 1 | Current code is an inhibit code |
| pgood_o | output | 1 | Power-good |
| ov_trip_o | output | 1 | Over-voltage trip from the last strobe |

## Verification
The bench walks all 32 codes. A decoder that reversed the downward-counting ranges, or that missed one of the reserved groups, would show a wrong reference or inhibit flag. Readings are placed exactly on each threshold and on the value one below it. A design that used the wrong inequality, or that dropped a hysteresis edge, would flip power-good one sample too early or too late. The bench also removes the strobe while the reading leaves the window, leaves inhibit and toggles the linear flags. A design that sampled without the strobe, or that kept stale edge state across inhibit, would raise power-good or the trip when it should not.

// File: rtl/pgmon_pkg.sv
package pgmon_pkg;
  localparam int VID_W = 5;

  // floor(mv * pct / 100) with enough headroom for any millivolt value used here
  function automatic logic [31:0] pct_of(input logic [31:0] mv, input logic [31:0] pct);
    return (mv * pct) / 32'd100;
  endfunction
endpackage

// File: rtl/vid_ref_decode.sv
module vid_ref_decode
  import pgmon_pkg::*;
#(
  parameter int MV_W        = 13,
  parameter int COARSE_TOP  = 3500,
  parameter int COARSE_STEP = 100,
  parameter int FINE_TOP    = 2050,
  parameter int FINE_STEP   = 50
) (
  input  logic [VID_W-1:0] code_i,
  output logic [MV_W-1:0]  ref_mv_o,
  output logic             inhibit_o
);
  int val;

  always_comb begin
    inhibit_o = 1'b0;
    val       = 0;
    if (code_i[4]) begin
      if (code_i[3:0] == 4'hF) inhibit_o = 1'b1;
      else val = COARSE_TOP - int'(code_i[3:0]) * COARSE_STEP;
    end else if (code_i[3]) begin
      inhibit_o = 1'b1;
    end else if (code_i[2] && code_i[1]) begin
      inhibit_o = 1'b1;
    end else begin
      val = FINE_TOP - int'(code_i[2:0]) * FINE_STEP;
    end
    ref_mv_o = MV_W'(val);
  end
endmodule

// File: rtl/hyst_edge.sv
module hyst_edge
  import pgmon_pkg::*;
#(
  parameter int MV_W    = 13,
  parameter int SET_PCT = 110,
  parameter int HYS_PCT = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr_i,
  input  logic            valid_i,
  input  logic [MV_W-1:0] ref_mv_i,
  input  logic [MV_W-1:0] sample_mv_i,
  output logic            above_o
);
  localparam int CLR_PCT = SET_PCT - HYS_PCT;

  logic [31:0] set_th, clr_th, smp;
  assign set_th = pct_of(32'(ref_mv_i), 32'(SET_PCT));
  assign clr_th = pct_of(32'(ref_mv_i), 32'(CLR_PCT));
  assign smp    = 32'(sample_mv_i);

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      above_o <= 1'b0;
    end else if (valid_i) begin
      if (!above_o && smp >= set_th) above_o <= 1'b1;
      else if (above_o && smp < clr_th) above_o <= 1'b0;
    end
  end

  assert_edge_holds_R8: assert property (@(posedge clk) disable iff (rst)
    (!valid_i && !clr_i) |=> $stable(above_o));
  assert_edge_flush_R10: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> !above_o);
endmodule

// File: rtl/core_pgood_mon.sv
module core_pgood_mon
  import pgmon_pkg::*;
#(
  parameter int MV_W    = 13,
  parameter int LO_PCT  = 93,
  parameter int HI_PCT  = 110,
  parameter int OV_PCT  = 115,
  parameter int HYS_PCT = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [VID_W-1:0] vid_code_i,
  input  logic             sample_valid_i,
  input  logic [MV_W-1:0]  core_mv_i,
  input  logic             lin_a_ok_i,
  input  logic             lin_b_ok_i,
  output logic [MV_W-1:0]  ref_mv_o,
  output logic             inhibit_o,
  output logic             pgood_o,
  output logic             ov_trip_o
);
  localparam int NEDGE = 2;  // 0 = lower edge, 1 = upper edge

  logic [MV_W-1:0]  dec_ref;
  logic             dec_inh;
  logic [NEDGE-1:0] above;
  logic [31:0]      ov_th;

  vid_ref_decode #(.MV_W(MV_W)) i_dec (
    .code_i(vid_code_i), .ref_mv_o(dec_ref), .inhibit_o(dec_inh)
  );

  for (genvar g = 0; g < NEDGE; g++) begin : g_edge
    localparam int PCT = (g == 0) ? LO_PCT : HI_PCT;
    hyst_edge #(.MV_W(MV_W), .SET_PCT(PCT), .HYS_PCT(HYS_PCT)) i_edge (
      .clk(clk), .rst(rst), .clr_i(inhibit_o), .valid_i(sample_valid_i),
      .ref_mv_i(ref_mv_o), .sample_mv_i(core_mv_i), .above_o(above[g])
    );
  end

  assign ov_th = pct_of(32'(ref_mv_o), 32'(OV_PCT));

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_mv_o  <= '0;
      inhibit_o <= 1'b0;
      ov_trip_o <= 1'b0;
      pgood_o   <= 1'b0;
    end else begin
      ref_mv_o  <= dec_ref;
      inhibit_o <= dec_inh;
      if (sample_valid_i) ov_trip_o <= !inhibit_o && (32'(core_mv_i) > ov_th);
      pgood_o   <= inhibit_o || (above[0] && !above[1] && lin_a_ok_i && lin_b_ok_i);
    end
  end

  assert_inhibit_release_R3: assert property (@(posedge clk) disable iff (rst)
    inhibit_o |=> pgood_o);
  assert_linear_gate_R6: assert property (@(posedge clk) disable iff (rst)
    (!inhibit_o && !(lin_a_ok_i && lin_b_ok_i)) |=> !pgood_o);
  assert_ov_holds_R8: assert property (@(posedge clk) disable iff (rst)
    !sample_valid_i |=> $stable(ov_trip_o));
  assert_ov_inhibit_R7: assert property (@(posedge clk) disable iff (rst)
    (sample_valid_i && inhibit_o) |=> !ov_trip_o);
endmodule

// File: tb/test_core_pgood_mon.sv
`timescale 1ns/1ps
module test_core_pgood_mon;
  localparam int MV_W = 13;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [4:0] code = 5'b00100;
  logic valid = 1'b0;
  logic [MV_W-1:0] rd = '0;
  logic la = 1'b1, lb = 1'b1;
  logic [MV_W-1:0] ref_o;
  logic inh_o, pg_o, ov_o;

  int checks = 0, failures = 0;
  string tag = "R9";
  bit done = 0;

  // model state
  int m_ref = 0;
  bit m_inh = 0, m_lo = 0, m_hi = 0, m_ov = 0, m_pg = 0;

  always #2 clk = ~clk;

  core_pgood_mon #(.MV_W(MV_W)) i_core_pgood_mon (
    .clk(clk), .rst(rst), .vid_code_i(code), .sample_valid_i(valid),
    .core_mv_i(rd), .lin_a_ok_i(la), .lin_b_ok_i(lb),
    .ref_mv_o(ref_o), .inhibit_o(inh_o), .pgood_o(pg_o), .ov_trip_o(ov_o)
  );

  function automatic bit exp_inh(input logic [4:0] c);
    return (c == 5'b11111) || (c[4:3] == 2'b01) || (c[4:1] == 4'b0011);
  endfunction

  function automatic int exp_ref(input logic [4:0] c);
    if (exp_inh(c)) return 0;
    if (c[4]) return 3500 - 100 * int'(c[3:0]);
    return 2050 - 50 * int'(c[2:0]);
  endfunction

  function automatic int pct(input int r, input int p);
    return (r * p) / 100;
  endfunction

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
    end
  endtask

  task automatic cyc();
    bit n_pg;
    @(posedge clk);
    if (rst) begin
      m_ref = 0; m_inh = 0; m_lo = 0; m_hi = 0; m_ov = 0; m_pg = 0;
    end else begin
      n_pg = m_inh || (m_lo && !m_hi && la && lb);
      if (valid) m_ov = !m_inh && (int'(rd) > pct(m_ref, 115));
      if (m_inh) begin
        m_lo = 0; m_hi = 0;
      end else if (valid) begin
        if (!m_lo && int'(rd) >= pct(m_ref, 93)) m_lo = 1;
        else if (m_lo && int'(rd) < pct(m_ref, 91)) m_lo = 0;
        if (!m_hi && int'(rd) >= pct(m_ref, 110)) m_hi = 1;
        else if (m_hi && int'(rd) < pct(m_ref, 108)) m_hi = 0;
      end
      m_pg = n_pg;
      m_ref = exp_ref(code);
      m_inh = exp_inh(code);
    end
    @(negedge clk);
    chk("ref_mv", int'(ref_o), m_ref);
    chk("inhibit", int'(inh_o), int'(m_inh));
    chk("pgood", int'(pg_o), int'(m_pg));
    chk("ov_trip", int'(ov_o), int'(m_ov));
  endtask

  task automatic samp(input int v);
    rd = MV_W'(v); valid = 1'b1; cyc();
    valid = 1'b0; cyc();
  endtask

  initial begin
    int r;
    void'($urandom(32'h5EED_0017));
    @(negedge clk);
    tag = "R9 reset"; cyc(); cyc();
    rst = 1'b0;
    tag = "R9 no sample yet"; cyc(); cyc(); cyc();

    // code sweep
    for (int c = 0; c < 32; c++) begin
      code = 5'(c);
      tag = exp_inh(5'(c)) ? "R3 inhibit code" : (c >= 16 ? "R1 coarse" : "R2 fine");
      cyc(); cyc();
    end

    // threshold corners on 1850 mV
    code = 5'b00100; cyc(); cyc();
    r = 1850;
    tag = "R5 below low set";    samp(pct(r, 93) - 1);
    tag = "R5 at low set";       samp(pct(r, 93));
    tag = "R4 below high set";   samp(pct(r, 110) - 1);
    tag = "R4 at high set";      samp(pct(r, 110));
    tag = "R4 at high release";  samp(pct(r, 108));
    tag = "R4 below release";    samp(pct(r, 108) - 1);
    tag = "R5 at low release";   samp(pct(r, 91));
    tag = "R5 below release";    samp(pct(r, 91) - 1);
    tag = "R7 at ov threshold";  samp(pct(r, 115));
    tag = "R7 above ov";         samp(pct(r, 115) + 1);

    // strobe-less reading ignored
    tag = "R8 setup"; samp(r);
    tag = "R8 no strobe"; rd = MV_W'(4000); cyc(); cyc(); rd = '0; cyc(); cyc();

    // linear flags
    tag = "R6 lin a low"; la = 1'b0; cyc(); cyc();
    tag = "R6 lin b low"; la = 1'b1; lb = 1'b0; cyc(); cyc();
    lb = 1'b1; cyc();

    // inhibit flush then return
    tag = "R3 inhibit with ov"; code = 5'b11111; cyc(); samp(4000);
    tag = "R10 back from inhibit"; code = 5'b10000; cyc(); cyc(); cyc();
    samp(3500);
    tag = "R10 code change"; code = 5'b00101; cyc(); samp(1800);

    // constrained random
    for (int i = 0; i < 1500; i++) begin
      logic [4:0] c;
      int base;
      c = ($urandom % 8 == 0) ? 5'($urandom) : code;
      if ($urandom % 16 == 0) c = 5'($urandom);
      code = c;
      base = exp_ref(c) == 0 ? 2000 : exp_ref(c);
      rd = MV_W'(pct(base, 85 + int'($urandom % 36)));
      valid = ($urandom % 3) != 0;
      la = ($urandom % 10) != 0;
      lb = ($urandom % 10) != 0;
      tag = "R1 R2 R3 R4 R5 R6 R7 R8 R10 random";
      cyc();
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule